// File: doc/BRIEF.md
# Descending Stack Bounds Monitor

This block keeps a shadow copy of a full-descending stack pointer and checks it against a configured base and limit. The pointer always addresses the most recently stored word. A push of N words moves it down by N words before the data would be written, and a pop of N words reads upward from it and then moves it up by N words. The block does no memory access. It only tracks the pointer and reports when the pointer leaves the permitted window.

Software or a sequencer loads a base and a limit, and the same load sets the pointer to the base. It then reports each push or pop with a word count from 1 to 16. After a push the new pointer is compared with the limit, and after a pop it is compared with the base. Error flags stay set until they are cleared explicitly. The pointer moves even when an operation raises an error, so the faulting value can be read from the output.

Top module: `stack_guard`

## Requirements
- R1: After the asynchronous reset, sp_o is zero and ovf_o, udf_o, proto_err_o and cfg_err_o are all low.
- R2: When cfg_load_i is high at a clock edge, sp_o becomes cfg_base_i, and base and limit are latched from cfg_base_i and cfg_limit_i. Any push or pop presented in the same cycle is ignored.
- R3: A load whose cfg_limit_i is greater than or equal to cfg_base_i (unsigned) sets cfg_err_o. A load with the limit below the base clears cfg_err_o.
- R4: A push (push_i high, pop_i low) with count_i from 1 to 16 lowers sp_o by 4*count_i bytes, modulo 2^ADDR_W.
- R5: A pop (pop_i high, push_i low) with count_i from 1 to 16 raises sp_o by 4*count_i bytes, modulo 2^ADDR_W.
- R6: After a push, ovf_o is set if the new pointer is below the latched limit (unsigned) or the subtraction wrapped below zero. A pointer equal to the limit is not an error. The pointer is updated in either case.
- R7: After a pop, udf_o is set if the new pointer is above the latched base (unsigned) or the addition wrapped past the top of the address space. A pointer equal to the base is not an error. The pointer is updated in either case.
- R8: ovf_o, udf_o, proto_err_o and cfg_err_o hold until clear_i is high at an edge. An error raised in the same cycle as a clear leaves its flag set.
- R9: push_i and pop_i high together set proto_err_o and leave sp_o unchanged.
- R10: A push or pop with count_i equal to 0 or greater than 16 sets proto_err_o and leaves sp_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_base_i | input | ADDR_W | Stack base (highest address, initial pointer) |
| cfg_limit_i | input | ADDR_W | Lowest permitted pointer value |
| cfg_load_i | input | 1 | Latch base and limit and set the pointer to the base |
| clear_i | input | 1 | Clear all error flags |
| push_i | input | 1 | Push event |
| pop_i | input | 1 | Pop event |
| count_i | input | CNT_W | Words moved by the event (1 to MAX_CNT) |
| sp_o | output | ADDR_W | Current tracked pointer |
| ovf_o | output | 1 | Sticky overflow (limit) error |
| udf_o | output | 1 | Sticky underflow (base) error |
| proto_err_o | output | 1 | Sticky bad-event error |
| cfg_err_o | output | 1 | Configuration error: limit not below base |

## Verification
A wrong pointer shows up on sp_o in the cycle right after the faulty event. From then on every later push or pop is measured against a shifted value, so the error also surfaces in ovf_o and udf_o at the wrong boundary. A latched base or limit that is off by one word changes only the overflow and underflow decision. It becomes visible only when an operation lands exactly on, or one word past, the boundary, which is why the bench steps to each edge and one word beyond it. A flag that is not sticky shows up on the idle cycle after the error.

// File: rtl/stack_guard_pkg.sv
package stack_guard_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_BAD  = 2'd3
  } op_e;

  localparam int unsigned FLG_OVF   = 0;
  localparam int unsigned FLG_UDF   = 1;
  localparam int unsigned FLG_PROTO = 2;
  localparam int unsigned NUM_FLG   = 3;
endpackage

// File: rtl/stack_guard_dec.sv
module stack_guard_dec
  import stack_guard_pkg::*;
#(
  parameter int unsigned MAX_CNT = 16,
  parameter int unsigned CNT_W   = $clog2(MAX_CNT + 1)
) (
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] count_i,
  output op_e              op_o
);
  logic cnt_ok;
  assign cnt_ok = (count_i != '0) && (count_i <= CNT_W'(MAX_CNT));

  always_comb begin
    op_o = OP_NONE;
    if (push_i && pop_i)        op_o = OP_BAD;
    else if (push_i || pop_i) begin
      if (!cnt_ok)              op_o = OP_BAD;
      else if (push_i)          op_o = OP_PUSH;
      else                      op_o = OP_POP;
    end
  end
endmodule

// File: rtl/stack_guard_cfg.sv
module stack_guard_cfg #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] limit_o,
  output logic              cfg_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o    <= '0;
      limit_o   <= '0;
      cfg_err_o <= 1'b0;
    end else if (load_i) begin
      base_o    <= base_i;
      limit_o   <= limit_i;
      cfg_err_o <= (limit_i >= base_i);
    end else if (clear_i) begin
      cfg_err_o <= 1'b0;
    end
  end

  AST_CFG_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (limit_i >= base_i)) |=> cfg_err_o); // R3
  AST_CFG_ERR_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (limit_i < base_i)) |=> !cfg_err_o); // R3
endmodule

// File: rtl/stack_guard_ptr.sv
module stack_guard_ptr
  import stack_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  op_e               op_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] base_q_i,
  input  logic [ADDR_W-1:0] limit_q_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic              ovf_evt_o,
  output logic              udf_evt_o
);
  localparam int unsigned SHIFT = $clog2(WORD_BYTES);

  logic [ADDR_W-1:0] bytes;
  logic [ADDR_W:0]   dn_ext, up_ext;
  logic [ADDR_W-1:0] sp_q, sp_d;

  assign bytes  = ADDR_W'(count_i) << SHIFT;
  assign dn_ext = {1'b0, sp_q} - {1'b0, bytes};
  assign up_ext = {1'b0, sp_q} + {1'b0, bytes};

  always_comb begin
    sp_d      = sp_q;
    ovf_evt_o = 1'b0;
    udf_evt_o = 1'b0;
    if (load_i) begin
      sp_d = load_val_i;
    end else begin
      unique case (op_i)
        OP_PUSH: begin
          sp_d      = dn_ext[ADDR_W-1:0];
          ovf_evt_o = dn_ext[ADDR_W] || (dn_ext[ADDR_W-1:0] < limit_q_i);
        end
        OP_POP: begin
          sp_d      = up_ext[ADDR_W-1:0];
          udf_evt_o = up_ext[ADDR_W] || (up_ext[ADDR_W-1:0] > base_q_i);
        end
        default: sp_d = sp_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= '0;
    else         sp_q <= sp_d;
  end

  assign sp_o = sp_q;

  AST_EVT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_evt_o && udf_evt_o)); // R6 R7
  AST_BAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && op_i == OP_BAD) |=> $stable(sp_q)); // R9 R10
endmodule

// File: rtl/stack_guard_flags.sv
module stack_guard_flags #(
  parameter int unsigned NUM = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic [NUM-1:0] evt_i,
  output logic [NUM-1:0] flg_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flg_o[g] <= 1'b0;
      else         flg_o[g] <= (flg_o[g] && !clear_i) || evt_i[g];
    end

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flg_o[g] && !clear_i) |=> flg_o[g]); // R8
    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> flg_o[g]); // R8
  end
endmodule

// File: rtl/stack_guard.sv
module stack_guard
  import stack_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned MAX_CNT    = 16,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned CNT_W      = $clog2(MAX_CNT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_limit_i,
  input  logic              cfg_load_i,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic              ovf_o,
  output logic              udf_o,
  output logic              proto_err_o,
  output logic              cfg_err_o
);
  localparam int unsigned SHIFT = $clog2(WORD_BYTES);

  op_e               op;
  logic [ADDR_W-1:0] base_q, limit_q;
  logic              ovf_evt, udf_evt;
  logic [NUM_FLG-1:0] evt, flg;

  stack_guard_dec #(.MAX_CNT(MAX_CNT), .CNT_W(CNT_W)) u_dec (
    .push_i (push_i),
    .pop_i  (pop_i),
    .count_i(count_i),
    .op_o   (op)
  );

  stack_guard_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cfg_load_i),
    .clear_i  (clear_i),
    .base_i   (cfg_base_i),
    .limit_i  (cfg_limit_i),
    .base_o   (base_q),
    .limit_o  (limit_q),
    .cfg_err_o(cfg_err_o)
  );

  stack_guard_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cfg_load_i),
    .load_val_i(cfg_base_i),
    .op_i      (op),
    .count_i   (count_i),
    .base_q_i  (base_q),
    .limit_q_i (limit_q),
    .sp_o      (sp_o),
    .ovf_evt_o (ovf_evt),
    .udf_evt_o (udf_evt)
  );

  always_comb begin
    evt            = '0;
    evt[FLG_OVF]   = ovf_evt;
    evt[FLG_UDF]   = udf_evt;
    evt[FLG_PROTO] = !cfg_load_i && (op == OP_BAD);
  end

  stack_guard_flags #(.NUM(NUM_FLG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .evt_i  (evt),
    .flg_o  (flg)
  );

  assign ovf_o       = flg[FLG_OVF];
  assign udf_o       = flg[FLG_UDF];
  assign proto_err_o = flg[FLG_PROTO];

  AST_LOAD_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> (sp_o == $past(cfg_base_i))); // R2
  AST_PUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_load_i && push_i && !pop_i && count_i != '0 && count_i <= CNT_W'(MAX_CNT))
    |=> (sp_o == $past(sp_o) - (ADDR_W'($past(count_i)) << SHIFT))); // R4
  AST_POP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_load_i && pop_i && !push_i && count_i != '0 && count_i <= CNT_W'(MAX_CNT))
    |=> (sp_o == $past(sp_o) + (ADDR_W'($past(count_i)) << SHIFT))); // R5
  AST_DUAL_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_load_i && push_i && pop_i) |=> proto_err_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_load_i && !push_i && !pop_i) |=> $stable(sp_o)); // R2
endmodule

// File: tb/tb_stack_guard.sv
module tb_stack_guard;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_i = '0, limit_i = '0;
  logic        load = 1'b0, clr = 1'b0, push = 1'b0, pop = 1'b0;
  logic [4:0]  cnt = '0;
  logic [31:0] sp;
  logic        ovf, udf, pro, cfe;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_sp = '0, m_base = '0, m_lim = '0;
  logic        m_ovf = 1'b0, m_udf = 1'b0, m_pro = 1'b0, m_cfg = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  stack_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_base_i(base_i), .cfg_limit_i(limit_i),
    .cfg_load_i(load), .clear_i(clr), .push_i(push), .pop_i(pop), .count_i(cnt),
    .sp_o(sp), .ovf_o(ovf), .udf_o(udf), .proto_err_o(pro), .cfg_err_o(cfe)
  );

  task automatic chk(input string what, input logic [31:0] act, exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk("sp_o", sp, m_sp, tag);
    chk("ovf_o", 32'(ovf), 32'(m_ovf), tag);
    chk("udf_o", 32'(udf), 32'(m_udf), tag);
    chk("proto_err_o", 32'(pro), 32'(m_pro), tag);
    chk("cfg_err_o", 32'(cfe), 32'(m_cfg), tag);
  endtask

  task automatic step(input logic ps, pp, input int n, input logic ld, cl,
                      input logic [31:0] b, l, input string tag);
    logic [32:0] t;
    @(negedge clk);
    push = ps; pop = pp; cnt = 5'(n); load = ld; clr = cl; base_i = b; limit_i = l;
    @(posedge clk);
    if (cl) begin m_ovf = 1'b0; m_udf = 1'b0; m_pro = 1'b0; end
    if (ld) begin
      m_sp = b; m_base = b; m_lim = l; m_cfg = (l >= b);
    end else begin
      if (cl) m_cfg = 1'b0;
      if (ps && pp) m_pro = 1'b1;
      else if (ps || pp) begin
        if (n < 1 || n > 16) m_pro = 1'b1;
        else if (ps) begin
          t = {1'b0, m_sp} - 33'(n * 4);
          if (t[32] || t[31:0] < m_lim) m_ovf = 1'b1;
          m_sp = t[31:0];
        end else begin
          t = {1'b0, m_sp} + 33'(n * 4);
          if (t[32] || t[31:0] > m_base) m_udf = 1'b1;
          m_sp = t[31:0];
        end
      end
    end
    #1;
    compare(tag);
    push = 1'b0; pop = 1'b0; load = 1'b0; clr = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 3);
    compare("R1");
    @(negedge clk); rst_n = 1'b1;
    #1; compare("R1");

    // sweep every count: push then pop back to base
    for (int n = 1; n <= 16; n++) begin
      step(0, 0, 0, 1, 1, 32'h100, 32'h0C0, "R2");
      step(1, 0, n, 0, 0, 32'h0, 32'h0, "R4");
      step(0, 1, n, 0, 0, 32'h0, 32'h0, "R5");
    end

    // limit boundary
    step(0, 0, 0, 1, 1, 32'h100, 32'h0C0, "R2");
    step(1, 0, 16, 0, 0, 0, 0, "R6");
    step(1, 0, 1, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 0, 0, "R8");
    // base boundary
    step(0, 1, 15, 0, 0, 0, 0, "R5");
    step(0, 1, 1, 0, 0, 0, 0, "R7");
    step(0, 1, 1, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 1, 2, 0, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 0, 0, "R8");

    // protocol errors
    step(1, 1, 2, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, 0, 0, "R8");
    step(1, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 1, 0, 0, "R8");
    step(0, 1, 17, 0, 0, 0, 0, "R10");
    step(1, 0, 31, 0, 0, 0, 0, "R10");

    // configuration
    step(0, 0, 0, 1, 1, 32'h200, 32'h200, "R3");
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 0, 4, 1, 0, 32'h300, 32'h280, "R2");
    step(0, 1, 4, 1, 0, 32'h400, 32'h500, "R3");

    // wrap cases
    step(0, 0, 0, 1, 1, 32'h10, 32'h0, "R2");
    step(1, 0, 4, 0, 0, 0, 0, "R6");
    step(1, 0, 8, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 1, 1, 32'hFFFF_FFF0, 32'hFFFF_FF00, "R2");
    step(0, 1, 8, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 0, 0, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule